// File: doc/BRIEF.md
# Photon Counting Pixel Cell

This block is the digital half of a single detector pixel. During an exposure it counts the pulses arriving from the pixel's threshold comparator. After the exposure the same storage register becomes a shift register. It presents its contents one bit per clock on a serial output line that many pixels of a column share. It also keeps a small per-pixel threshold correction code and raises a flag when both of its select lines are active, so that the analog monitor can be routed from this pixel.

Everything runs on one externally supplied clock. The comparator pulse is asynchronous to it. The pulse passes through a two-stage synchronizer and a rising-edge detector, so a hit adds exactly one count whatever its length. The counter sticks at all ones and never wraps. Readout and trim loading take place only while the exposure enable is low and both the row select and the column select are high. The program strobe then chooses between shifting the count out and shifting a trim code in.

No valid/ready handshake exists on the serial path, and the pixel cannot apply back-pressure. The column controller paces the transfer by holding the selects for as many clocks as it wants bits. When it drops a select, the register simply keeps its partly shifted state.

Top module: `pixel_cell`

## Requirements
- R1: After reset the count is zero, the trim code is 0, and the serial output is low.
- R2: While the enable is high, each rising edge of the comparator input adds exactly one to the count, however many clocks the input then stays high.
- R3: The count saturates at its all-ones value (2^CNT_W - 1) and stays there when further hits arrive.
- R4: While the enable is low, comparator hits leave the count unchanged.
- R5: With the enable low, both selects high and the program strobe low, the output shows the count's most significant bit. Each clock then shifts the count one place toward the MSB, so 20 clocks deliver all bits MSB first.
- R6: Each shift brings a zero in at the LSB, so after a full 20-clock readout the count is zero and a second readout returns all zeros.
- R7: The serial output is low whenever the enable is high or either select is low, and such cycles do not disturb the stored count.
- R8: With the enable low, both selects high and the program strobe high, each clock shifts the data input into the trim code from the top. After TRIM_W clocks, the first bit sent sits in bit 0 (LSB first). The serial output stays low during loading.
- R9: The trim code holds its value whenever the program strobe is low or the pixel is not selected.
- R10: The monitor select output is high exactly when both the row select and the column select are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External readout and system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 1 | Comparator output pulse, asynchronous |
| cnt_en_i | input | 1 | Exposure enable; high means counting |
| row_sel_i | input | 1 | Row select line |
| col_sel_i | input | 1 | Column select line |
| prog_i | input | 1 | Program strobe: load trim instead of reading out |
| din_i | input | 1 | Serial data in for trim loading |
| dout_o | output | 1 | Serial count out, low when idle |
| trim_o | output | TRIM_W | Threshold trim code |
| mon_sel_o | output | 1 | Analog monitor route select |

## Verification
The checker watches several properties on every cycle. It confirms that the count grows by no more than one per clock while counting, and that the count holds at saturation. It also confirms that the count is frozen when the pixel is neither counting nor selected, and that each selected readout clock shifts the register left with a zero entering. For the trim code, it checks that each load clock shifts in the data bit and that the code is stable at all other times. The idle output must be low. Only the bench scenarios show end-to-end facts: a long comparator pulse counts once, hits during a disabled exposure vanish, the bit order on the wire is right, a small counter stops at its all-ones value, and a second readout after a full one returns zeros.

// File: rtl/pixel_pkg.sv
package pixel_pkg;
  localparam int CNT_W_DEF  = 20;
  localparam int TRIM_W_DEF = 6;
  localparam int SYNC_DEF   = 2;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_SHIFT = 2'd2,
    MODE_PROG  = 2'd3
  } pix_mode_e;
endpackage

// File: rtl/pixel_hit_sync.sv
module pixel_hit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] stage_q;
  logic              last_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= 1'b0;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= stage_q[STAGES-1];
  end

  assign rise_o = stage_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pixel_count_shift.sv
module pixel_count_shift
  import pixel_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pix_mode_e        mode_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case (mode_i)
        MODE_COUNT: if (inc_i && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
        MODE_SHIFT: cnt_q <= {cnt_q[CNT_W-2:0], 1'b0};
        default:    cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pixel_trim_reg.sv
module pixel_trim_reg #(
  parameter int TRIM_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              bit_i,
  output logic [TRIM_W-1:0] trim_o
);
  logic [TRIM_W-1:0] trim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      trim_q <= '0;
    else if (load_i) trim_q <= {bit_i, trim_q[TRIM_W-1:1]};
  end

  assign trim_o = trim_q;
endmodule

// File: rtl/pixel_cell.sv
module pixel_cell
  import pixel_pkg::*;
#(
  parameter int CNT_W       = CNT_W_DEF,
  parameter int TRIM_W      = TRIM_W_DEF,
  parameter int SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic              cnt_en_i,
  input  logic              row_sel_i,
  input  logic              col_sel_i,
  input  logic              prog_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic              mon_sel_o
);
  pix_mode_e        mode;
  logic             hit_rise;
  logic [CNT_W-1:0] cnt_q;
  logic             addr_hit;

  assign addr_hit = row_sel_i & col_sel_i;

  always_comb begin
    if (cnt_en_i)      mode = MODE_COUNT;
    else if (!addr_hit) mode = MODE_IDLE;
    else if (prog_i)   mode = MODE_PROG;
    else               mode = MODE_SHIFT;
  end

  pixel_hit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(hit_i),
    .rise_o (hit_rise)
  );

  pixel_count_shift #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .mode_i(mode),
    .inc_i (hit_rise),
    .cnt_o (cnt_q)
  );

  pixel_trim_reg #(.TRIM_W(TRIM_W)) u_trim (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(mode == MODE_PROG),
    .bit_i (din_i),
    .trim_o(trim_o)
  );

  assign dout_o    = (mode == MODE_SHIFT) ? cnt_q[CNT_W-1] : 1'b0;
  assign mon_sel_o = addr_hit;
endmodule

// File: rtl/pixel_cell_chk.sv
module pixel_cell_chk #(
  parameter int CNT_W  = 20,
  parameter int TRIM_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en_i,
  input logic              row_sel_i,
  input logic              col_sel_i,
  input logic              prog_i,
  input logic              din_i,
  input logic              dout_o,
  input logic [TRIM_W-1:0] trim_o,
  input logic [CNT_W-1:0]  cnt_q
);
  logic sel_rd, sel_pg;
  assign sel_rd = !cnt_en_i && row_sel_i && col_sel_i && !prog_i;
  assign sel_pg = !cnt_en_i && row_sel_i && col_sel_i && prog_i;

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_i && !(&cnt_q) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  p_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_i && (&cnt_q) |=> (&cnt_q));

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en_i && !(row_sel_i && col_sel_i) |=> $stable(cnt_q));

  p_shift_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rd |=> cnt_q == {$past(cnt_q[CNT_W-2:0]), 1'b0});

  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_rd |-> !dout_o);

  p_trim_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pg |=> trim_o == {$past(din_i), $past(trim_o[TRIM_W-1:1])});

  p_trim_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_pg |=> $stable(trim_o));
endmodule

bind pixel_cell pixel_cell_chk #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en_i (cnt_en_i),
  .row_sel_i(row_sel_i),
  .col_sel_i(col_sel_i),
  .prog_i   (prog_i),
  .din_i    (din_i),
  .dout_o   (dout_o),
  .trim_o   (trim_o),
  .cnt_q    (cnt_q)
);

// File: tb/pixel_cell_bench.sv
`timescale 1ns/1ps
module pixel_cell_bench;
  localparam int W  = 20;
  localparam int WS = 4;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst_n, hit, en, row, col, prog, din;
  logic dout, dout_s, mon, mon_s;
  logic [TW-1:0] trim, trim_s;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit rd_active = 1'b0;

  logic  q_main[$];
  logic  q_sat[$];
  string q_tag[$];
  int unsigned exp_cnt = 0;

  always #2.5 clk = ~clk;

  pixel_cell u_pixel_cell (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .cnt_en_i(en),
    .row_sel_i(row), .col_sel_i(col), .prog_i(prog), .din_i(din),
    .dout_o(dout), .trim_o(trim), .mon_sel_o(mon)
  );

  pixel_cell #(.CNT_W(WS)) u_pixel_cell_sat (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .cnt_en_i(en),
    .row_sel_i(row), .col_sel_i(col), .prog_i(prog), .din_i(din),
    .dout_o(dout_s), .trim_o(trim_s), .mon_sel_o(mon_s)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: pops expected bits and compares at falling edges
  always @(negedge clk) begin
    if (rd_active) begin
      if (q_main.size() == 0) begin
        check("R5 queue underflow", 1, 0);
      end else begin
        check(q_tag.pop_front(), dout, q_main.pop_front());
        check("R3 saturated readout", dout_s, q_sat.pop_front());
      end
    end
  end

  task automatic hit_pulse(input int len);
    hit = 1'b1;
    repeat (len) tick();
    hit = 1'b0;
    repeat (4) tick();
    if (en && exp_cnt < (1 << W) - 1) exp_cnt++;
  endtask

  task automatic readout(input string tag);
    int unsigned sat_v;
    sat_v = (exp_cnt > 15) ? 15 : exp_cnt;
    for (int i = W - 1; i >= 0; i--) begin
      q_main.push_back(exp_cnt[i]);
      q_tag.push_back(tag);
    end
    for (int i = 0; i < W; i++) q_sat.push_back(i < WS ? sat_v[WS-1-i] : 1'b0);
    en = 1'b0; prog = 1'b0; row = 1'b1; col = 1'b1; rd_active = 1'b1;
    repeat (W) @(posedge clk);
    #1;
    row = 1'b0; col = 1'b0; rd_active = 1'b0;
    check("R5 queue drained", q_main.size(), 0);
    exp_cnt = 0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [TW-1:0] code;
    rst_n = 1'b0; hit = 1'b0; en = 1'b0; row = 1'b0; col = 1'b0; prog = 1'b0; din = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 dout after reset", dout, 0);
    check("R1 trim after reset", trim, 0);
    check("R1 mon_sel after reset", mon, 0);
    readout("R1 zero count");

    // R2: short and long pulses
    en = 1'b1;
    repeat (5) hit_pulse(1);
    repeat (3) hit_pulse(6);
    check("R2 model count", exp_cnt, 8);
    row = 1'b1; col = 1'b1;
    tick();
    check("R7 dout low while counting", dout, 0);
    row = 1'b0; col = 1'b0;
    en = 1'b0;
    tick();
    repeat (3) hit_pulse(2);          // R4: ignored while disabled
    row = 1'b1; col = 1'b0;
    repeat (3) tick();
    check("R7 dout low, column not selected", dout, 0);
    check("R10 mon_sel one select", mon, 0);
    row = 1'b0;
    tick();
    readout("R4 R5 count of eight");
    readout("R6 cleared after readout");

    // R3: small instance saturates, main instance keeps counting
    en = 1'b1;
    repeat (45) hit_pulse(1);
    en = 1'b0;
    tick();
    readout("R5 count 45");

    // R8: trim load LSB first
    code = 6'b101101;
    row = 1'b1; col = 1'b1; prog = 1'b1;
    for (int i = 0; i < TW; i++) begin
      din = code[i];
      @(negedge clk);
      check("R8 dout low while programming", dout, 0);
      @(posedge clk);
      #1;
    end
    prog = 1'b0;
    check("R8 trim loaded", trim, code);
    check("R10 mon_sel both selects", mon, 1);

    // R9: hold when strobe low or not selected
    din = 1'b0;
    repeat (3) tick();
    check("R9 trim holds, strobe low", trim, code);
    row = 1'b0; prog = 1'b1;
    repeat (3) tick();
    check("R9 trim holds, not selected", trim, code);
    row = 1'b1; en = 1'b1;
    repeat (3) tick();
    check("R9 trim holds while counting", trim, code);
    row = 1'b0; col = 1'b0; prog = 1'b0; en = 1'b0;
    tick();

    done = 1'b1;
    finish_run();
  end
endmodule